// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is a small memory-mapped register frame that sits between a bus master issuing message-signalled interrupts and a bank of wired interrupt inputs on an interrupt controller. A master writes an absolute interrupt ID into the doorbell register. The frame takes away the start of its window, which is 32 plus the configured base, and checks that the result names one of its own lines. If it does, the frame pulses that line for a single clock cycle. Out-of-window IDs are dropped silently.

Two read-only registers let software find the frame. The type register packs the first absolute ID and the line count into one word. The interface identification register returns a fixed product, revision and implementer code. Every other offset reads as zero. Accesses that are not exactly four bytes wide are ignored: a read returns zero and a write changes nothing. Two elaboration parameters set the base in the shared-peripheral number space (`BASE_SPI`, where 0 means absolute ID 32) and the number of lines (`LINE_COUNT`, 1 to 128).

Top module: `msi_frame_bridge`

## Requirements
- R1: A four-byte read of offset 0x008 returns, one cycle after the request, (BASE_SPI+32) in bits [31:16] and LINE_COUNT in bits [15:0].
- R2: A four-byte read of offset 0xFCC returns 0x0510043B one cycle after the request: product 0x051 in [31:20], revision 0 in [19:16], implementer 0x43B in [11:0].
- R3: Four-byte reads of offsets 0xFD4 to 0xFFC, and of every offset other than 0x008 and 0xFCC, return zero.
- R4: A four-byte write to offset 0x040 takes bits [9:0] of the write data as an absolute ID and ignores bits [31:10]. If the ID lies in BASE_SPI+32 to BASE_SPI+31+LINE_COUNT, output bit (ID-BASE_SPI-32) is high in exactly the cycle after the write, and every other output bit stays low.
- R5: A doorbell ID below BASE_SPI+32 or above BASE_SPI+31+LINE_COUNT raises no output line.
- R6: An access with req_size (a byte count) other than 4 is ignored: a read returns zero and a doorbell write raises no line.
- R7: Writes to any offset other than 0x040 raise no line.
- R8: Doorbell writes in consecutive cycles each produce their own one-cycle assertion, so a line is high for one cycle per accepted write and low again once the writes stop.
- R9: The read data is zero in every cycle that does not follow a qualifying read, including the cycles after writes and idle cycles.
- R10: While the synchronous active-high reset is applied, the read data and all output lines are zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W (12) | Byte offset within the frame |
| req_wdata | input | 32 | Write data |
| req_size | input | 3 | Access width as a byte count |
| rd_data | output | 32 | Registered read data, valid the cycle after a read |
| irq_pulse | output | LINE_COUNT | One-cycle pulse per interrupt line |

## Verification
The assertions assume that the inputs are stable and known at each rising edge and that reset is applied at time zero. They also assume the parameters keep the window inside the 10-bit ID space, so the top end of the window can never wrap. The bench changes inputs only on falling edges and holds reset high for several cycles before any access. Its random doorbell IDs are drawn from a band around the window, with sometimes-set upper data bits, so that both window edges and the masking of the upper bits are reached while the IDs stay meaningful.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam int unsigned DATA_W       = 32;
    localparam int unsigned ID_W         = 10;
    localparam int unsigned MAX_LINES    = 128;
    localparam int unsigned SPI_OFFSET   = 32;

    localparam logic [11:0] OFS_TYPE     = 12'h008;
    localparam logic [11:0] OFS_BELL     = 12'h040;
    localparam logic [11:0] OFS_IDENT    = 12'hFCC;

    localparam logic [2:0]  FULL_WORD    = 3'd4;

    localparam logic [11:0] PRODUCT_CODE = 12'h051;
    localparam logic [3:0]  REVISION     = 4'h0;
    localparam logic [11:0] IMPL_CODE    = 12'h43B;

    localparam logic [DATA_W-1:0] IDENT_WORD =
        {PRODUCT_CODE, REVISION, 4'h0, IMPL_CODE};

    typedef struct packed {
        logic rd_type;
        logic rd_ident;
        logic rd_any;
        logic wr_bell;
    } access_t;

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
    import msi_frame_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    output access_t           acc
);

    logic sized_ok;

    always_comb begin
        sized_ok     = req_valid && (req_size == FULL_WORD);
        acc.rd_any   = sized_ok && !req_write;
        acc.rd_type  = acc.rd_any && (req_addr == ADDR_W'(OFS_TYPE));
        acc.rd_ident = acc.rd_any && (req_addr == ADDR_W'(OFS_IDENT));
        acc.wr_bell  = sized_ok && req_write && (req_addr == ADDR_W'(OFS_BELL));
    end

    // R6: nothing is qualified for an access of the wrong width
    always_comb begin
        if (req_valid && req_size != FULL_WORD) begin
            a_r6_size_gate: assert (!acc.rd_any && !acc.wr_bell);
        end
    end

endmodule

// File: rtl/msi_frame_regs.sv
module msi_frame_regs
    import msi_frame_pkg::*;
#(
    parameter int unsigned BASE_SPI   = 64,
    parameter int unsigned LINE_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [15:0] FIRST_ID = 16'(BASE_SPI + SPI_OFFSET);
    localparam logic [DATA_W-1:0] TYPE_WORD = {FIRST_ID, 16'(LINE_COUNT)};

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } regs_state_t;

    regs_state_t state_d, state_q;

    always_comb begin
        state_d = '0;
        if (acc.rd_type) begin
            state_d.rdata = TYPE_WORD;
        end else if (acc.rd_ident) begin
            state_d.rdata = IDENT_WORD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rdata;

    a_r1_type_word: assert property (@(posedge clk) disable iff (rst)
        acc.rd_type |=> (rd_data == TYPE_WORD));

    a_r2_ident_word: assert property (@(posedge clk) disable iff (rst)
        acc.rd_ident |=> (rd_data == IDENT_WORD));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !acc.rd_any |=> (rd_data == '0));

endmodule

// File: rtl/msi_frame_doorbell.sv
module msi_frame_doorbell
    import msi_frame_pkg::*;
#(
    parameter int unsigned BASE_SPI   = 64,
    parameter int unsigned LINE_COUNT = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_bell,
    input  logic [ID_W-1:0]       bell_id,
    output logic [LINE_COUNT-1:0] irq_pulse
);

    localparam int unsigned FIRST_ID = BASE_SPI + SPI_OFFSET;
    localparam int unsigned LAST_ID  = FIRST_ID + LINE_COUNT - 1;

    typedef struct packed {
        logic [LINE_COUNT-1:0] pulse;
    } bell_state_t;

    bell_state_t state_d, state_q;
    logic        in_window;
    logic [LINE_COUNT-1:0] line_hit;

    always_comb begin
        in_window = (bell_id >= ID_W'(FIRST_ID)) && (bell_id <= ID_W'(LAST_ID));
    end

    for (genvar i = 0; i < LINE_COUNT; i++) begin : g_line
        assign line_hit[i] = (bell_id == ID_W'(FIRST_ID + i));
    end

    always_comb begin
        state_d = '0;
        if (wr_bell && in_window) begin
            state_d.pulse = line_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_pulse = state_q.pulse;

    a_r4_single_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse));

    a_r5_outside_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_bell && !in_window) |=> (irq_pulse == '0));

    a_r7_needs_bell: assert property (@(posedge clk) disable iff (rst)
        !wr_bell |=> (irq_pulse == '0));

    a_r8_each_write_pulses: assert property (@(posedge clk) disable iff (rst)
        (wr_bell && in_window) |=> ($countones(irq_pulse) == 1));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (irq_pulse == '0));

endmodule

// File: rtl/msi_frame_bridge.sv
module msi_frame_bridge
    import msi_frame_pkg::*;
#(
    parameter int unsigned BASE_SPI   = 64,
    parameter int unsigned LINE_COUNT = 16,
    parameter int unsigned ADDR_W     = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [2:0]            req_size,
    output logic [DATA_W-1:0]     rd_data,
    output logic [LINE_COUNT-1:0] irq_pulse
);

    if (LINE_COUNT < 1 || LINE_COUNT > MAX_LINES) begin : g_bad_count
        $error("LINE_COUNT must be 1..128");
    end
    if (BASE_SPI + SPI_OFFSET + LINE_COUNT > (1 << ID_W)) begin : g_bad_base
        $error("frame window exceeds the 10-bit ID space");
    end

    access_t acc;

    msi_frame_decode #(
        .ADDR_W (ADDR_W)
    ) i_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .acc       (acc)
    );

    msi_frame_regs #(
        .BASE_SPI   (BASE_SPI),
        .LINE_COUNT (LINE_COUNT)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .rd_data (rd_data)
    );

    msi_frame_doorbell #(
        .BASE_SPI   (BASE_SPI),
        .LINE_COUNT (LINE_COUNT)
    ) i_bell (
        .clk       (clk),
        .rst       (rst),
        .wr_bell   (acc.wr_bell),
        .bell_id   (req_wdata[ID_W-1:0]),
        .irq_pulse (irq_pulse)
    );

    a_r6_narrow_read_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size != FULL_WORD) |=> (rd_data == '0));

    a_r6_narrow_write_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && req_size != FULL_WORD) |=> (irq_pulse == '0));

    a_r9_write_no_rdata: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rd_data == '0));

    a_r10_reset_rdata: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: tb/test_msi_frame_bridge.sv
`timescale 1ns/1ps
module test_msi_frame_bridge;

    localparam int unsigned BASE  = 64;
    localparam int unsigned LINES = 16;
    localparam int unsigned FIRST = BASE + 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_size  = 3'd4;
    logic [31:0] rd_data;
    logic [LINES-1:0] irq_pulse;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    msi_frame_bridge #(
        .BASE_SPI   (BASE),
        .LINE_COUNT (LINES),
        .ADDR_W     (12)
    ) i_msi_frame_bridge (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_size  (req_size),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    function automatic logic [31:0] exp_read(logic v, logic w, logic [11:0] a, logic [2:0] s);
        if (!v || w || s != 3'd4) return 32'h0;
        if (a == 12'h008) return {16'(FIRST), 16'(LINES)};
        if (a == 12'hFCC) return 32'h0510043B;
        return 32'h0;
    endfunction

    function automatic logic [LINES-1:0] exp_irq(logic v, logic w, logic [11:0] a,
                                                 logic [2:0] s, logic [31:0] d);
        int id;
        logic [LINES-1:0] r;
        r  = '0;
        id = int'(d[9:0]);
        if (v && w && s == 3'd4 && a == 12'h040 && id >= FIRST && id < FIRST + LINES)
            r[id - FIRST] = 1'b1;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] exp_rd, logic [LINES-1:0] exp_ln);
        total++;
        if (rd_data !== exp_rd || irq_pulse !== exp_ln) begin
            bad++;
            $display("FAIL %s: rd_data=%h irq=%h expected rd_data=%h irq=%h",
                     req, rd_data, irq_pulse, exp_rd, exp_ln);
        end
    endtask

    // drive one access, wait one edge, compare
    task automatic issue(string req, logic v, logic w, logic [11:0] a,
                         logic [2:0] s, logic [31:0] d);
        req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
        @(negedge clk);
        check(req, exp_read(v, w, a, s), exp_irq(v, w, a, s, d));
    endtask

    task automatic idle(string req);
        issue(req, 1'b0, 1'b0, 12'h000, 3'd4, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: rd_data=%h irq=%h expected completion", rd_data, irq_pulse);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] ofs_pool [6];
        logic [2:0]  size_pool [5];
        void'($urandom(32'd1234));
        ofs_pool  = '{12'h008, 12'h040, 12'hFCC, 12'hFD4, 12'hFFC, 12'h044};
        size_pool = '{3'd1, 3'd2, 3'd4, 3'd4, 3'd4};

        // R10: reset holds outputs low even with a live doorbell
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_wdata = 32'(FIRST);
        repeat (4) @(negedge clk);
        check("R10", 32'h0, '0);
        rst = 1'b0;
        idle("R10");

        issue("R1", 1, 0, 12'h008, 3'd4, 32'h0);
        issue("R2", 1, 0, 12'hFCC, 3'd4, 32'h0);
        issue("R3", 1, 0, 12'hFD4, 3'd4, 32'h0);
        issue("R3", 1, 0, 12'hFFC, 3'd4, 32'h0);
        issue("R3", 1, 0, 12'hFD0, 3'd4, 32'h0);
        issue("R3", 1, 0, 12'h040, 3'd4, 32'h0);
        issue("R9", 1, 1, 12'h008, 3'd4, 32'hFFFF_FFFF);
        idle("R9");

        // R4: window edges, upper data bits masked
        issue("R4", 1, 1, 12'h040, 3'd4, 32'(FIRST));
        idle("R4");
        issue("R4", 1, 1, 12'h040, 3'd4, 32'(FIRST + LINES - 1));
        idle("R4");
        issue("R4", 1, 1, 12'h040, 3'd4, 32'hABCD_FC00 | 32'(FIRST + 5));
        idle("R4");

        // R5: just outside, and far below (negative local index)
        issue("R5", 1, 1, 12'h040, 3'd4, 32'(FIRST - 1));
        issue("R5", 1, 1, 12'h040, 3'd4, 32'(FIRST + LINES));
        issue("R5", 1, 1, 12'h040, 3'd4, 32'd3);
        issue("R5", 1, 1, 12'h040, 3'd4, 32'h3FF);

        // R6: narrow accesses
        issue("R6", 1, 0, 12'h008, 3'd2, 32'h0);
        issue("R6", 1, 0, 12'hFCC, 3'd1, 32'h0);
        issue("R6", 1, 1, 12'h040, 3'd2, 32'(FIRST + 2));
        issue("R6", 1, 1, 12'h040, 3'd0, 32'(FIRST + 2));

        // R7: other offsets
        issue("R7", 1, 1, 12'h044, 3'd4, 32'(FIRST + 1));
        issue("R7", 1, 1, 12'h008, 3'd4, 32'(FIRST + 1));

        // R8: back-to-back to the same line and to different lines
        issue("R8", 1, 1, 12'h040, 3'd4, 32'(FIRST + 3));
        issue("R8", 1, 1, 12'h040, 3'd4, 32'(FIRST + 3));
        issue("R8", 1, 1, 12'h040, 3'd4, 32'(FIRST + 9));
        idle("R8");
        issue("R8", 1, 1, 12'h040, 3'd4, 32'(FIRST + 3));
        idle("R8");

        // random mix across all requirements
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            a = ($urandom_range(0, 3) == 0) ? 12'($urandom) & 12'hFFC
                                            : ofs_pool[$urandom_range(0, 5)];
            d = 32'(FIRST) - 32'd4 + 32'($urandom_range(0, LINES + 7));
            if ($urandom_range(0, 3) == 0) d = d | ($urandom & 32'hFFFF_FC00);
            issue("R4 R5 R6 R9 random", 1'($urandom_range(0, 4) != 0), 1'($urandom),
                  a, size_pool[$urandom_range(0, 4)], d);
        end
        idle("R9");

        // R10: reset in mid-run clears a pending pulse
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h040; req_size = 3'd4;
        req_wdata = 32'(FIRST + 7);
        rst = 1'b1;
        @(negedge clk);
        check("R10", 32'h0, '0);
        rst = 1'b0;
        idle("R10");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule